// File: doc/BRIEF.md
# Enable-Latched 1K x 1 Static Memory

This block is a 1024-word by 1-bit static memory whose address is held in an internal register. The register is loaded at the start of each access, when the active-low chip enable falls. It then holds that value until the enable rises and falls again. While the enable is low, the address pins can change freely and the access still goes to the location that was captured. Data enters on its own input pin and leaves on its own output pin. The output carries a drive flag that models a three-state buffer, so several of these memories can share one data line.

The enable is sampled by the system clock. The cycle in which the enable is seen falling both loads the address register and forwards the pin address to the array, so that cycle is already a valid access. The cells form a 32 x 32 matrix. Address bits [9:5] pick the row and bits [4:0] pick the column. Both decoders stay dark while the enable is high.

Top module: `latched_sram_1kx1`

## Requirements
- R1: A write stores the data input at the captured address, and a later read of that address returns the most recent value written there.
- R2: The address is captured in the clock cycle in which `ce_n` is first seen low after being high. Changes on `addr` while `ce_n` stays low have no effect on reads or writes.
- R3: While `ce_n` is high the captured address does not change. The next falling edge of `ce_n` captures a fresh address from `addr`.
- R4: Row index is `addr[9:5]` and column index is `addr[4:0]`. At most one row and one column are selected at a time, and none while `ce_n` is high. Two addresses that differ only in row bits, or only in column bits, are separate cells.
- R5: With `ce_n` low and `we_n` high, `q_oe` is 1 and `q` shows the bit stored at the captured address.
- R6: `q_oe` is 0 whenever `ce_n` is high or `we_n` is low, and `q` reads 0 whenever `q_oe` is 0.
- R7: While `ce_n` is held high, stored data is kept indefinitely, whatever happens on `we_n`, `d` and `addr`.
- R8: While `rst_n` is low and after its release, with `ce_n` high, `q_oe` is 0.
- R9: During a write access the cell follows `d` on every clock cycle in which `we_n` is low. The value present in the last such cycle is the one kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; `ce_n` and `we_n` are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| ce_n | input | 1 | Active-low chip enable; its falling edge captures the address |
| we_n | input | 1 | Active-low write enable |
| addr | input | 10 | Word address; bits [9:5] row, [4:0] column |
| d | input | 1 | Write data |
| q | output | 1 | Read data, 0 while not driven |
| q_oe | output | 1 | High when `q` is driven (three-state enable) |

## Verification
The sharpest case is an access whose address pins are scrambled right after the enable falls. A design that samples the pins continuously would write to, or read from, the scrambled location, and a later readback would then show a stale bit. A second case is the first cycle of an access. A design that only uses the registered address would read the previous access's location in that cycle, and would write there too. Long idle stretches with the write strobe and data toggling catch a design that lets writes through while the enable is high. A full fill and readback with row-only and column-only neighbours catches swapped or overlapping decoder fields.

// File: rtl/sram1k_pkg.sv
package sram1k_pkg;
  localparam int ROW_BITS_DEF = 5;
  localparam int COL_BITS_DEF = 5;
endpackage

// File: rtl/sram_addr_capture.sv
module sram_addr_capture #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic [AW-1:0] addr_pin,
  output logic          cap_now,
  output logic [AW-1:0] eff_addr
);
  logic          ce_seen_q, ce_seen_d;
  logic [AW-1:0] held_q, held_d;

  // falling enable: high last cycle, low now
  always_comb begin
    cap_now   = ce_seen_q & ~ce_n;
    ce_seen_d = ce_n;
    held_d    = cap_now ? addr_pin : held_q;
    eff_addr  = cap_now ? addr_pin : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_seen_q <= 1'b1;
      held_q    <= '0;
    end else begin
      ce_seen_q <= ce_seen_d;
      if (cap_now) held_q <= held_d;
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_now |=> $stable(held_q));

  // R2
  mid_cycle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !cap_now) |-> (eff_addr == held_q));
endmodule

// File: rtl/sram_decoder.sv
module sram_decoder #(
  parameter int W = 5,
  localparam int N = 1 << W
) (
  input  logic         en,
  input  logic [W-1:0] idx,
  output logic [N-1:0] sel
);
  always_comb begin
    sel = '0;
    if (en) sel[idx] = 1'b1;
  end
endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array #(
  parameter int RB = 5,
  parameter int CB = 5,
  localparam int ROWS = 1 << RB,
  localparam int COLS = 1 << CB
) (
  input  logic            clk,
  input  logic            wr,
  input  logic            din,
  input  logic [ROWS-1:0] row_sel,
  input  logic [COLS-1:0] col_sel,
  input  logic [RB-1:0]   rd_row,
  input  logic [CB-1:0]   rd_col,
  output logic            rd_bit
);
  logic [COLS-1:0] row_q [ROWS];
  logic [COLS-1:0] row_d [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic row_we;
    always_comb begin
      row_we   = wr & row_sel[r];
      row_d[r] = (row_q[r] & ~col_sel) | (col_sel & {COLS{din}});
    end
    always_ff @(posedge clk) begin
      if (row_we) row_q[r] <= row_d[r];
    end
  end

  always_comb rd_bit = row_q[rd_row][rd_col];
endmodule

// File: rtl/latched_sram_1kx1.sv
module latched_sram_1kx1
  import sram1k_pkg::*;
#(
  parameter int ROW_BITS = ROW_BITS_DEF,
  parameter int COL_BITS = COL_BITS_DEF,
  localparam int AW   = ROW_BITS + COL_BITS,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic          d,
  output logic          q,
  output logic          q_oe
);
  logic                cap_now;
  logic [AW-1:0]       eff_addr;
  logic [ROW_BITS-1:0] row_idx;
  logic [COL_BITS-1:0] col_idx;
  logic [ROWS-1:0]     row_sel;
  logic [COLS-1:0]     col_sel;
  logic                active, wr_en, cell_bit;

  sram_addr_capture #(.AW(AW)) i_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr_pin(addr),
    .cap_now(cap_now), .eff_addr(eff_addr)
  );

  always_comb begin
    row_idx = eff_addr[AW-1:COL_BITS];
    col_idx = eff_addr[COL_BITS-1:0];
    active  = ~ce_n;
    wr_en   = active & ~we_n;
  end

  sram_decoder #(.W(ROW_BITS)) i_row_dec (.en(active), .idx(row_idx), .sel(row_sel));
  sram_decoder #(.W(COL_BITS)) i_col_dec (.en(active), .idx(col_idx), .sel(col_sel));

  sram_cell_array #(.RB(ROW_BITS), .CB(COL_BITS)) i_array (
    .clk(clk), .wr(wr_en), .din(d), .row_sel(row_sel), .col_sel(col_sel),
    .rd_row(row_idx), .rd_col(col_idx), .rd_bit(cell_bit)
  );

  always_comb begin
    q_oe = active & we_n;
    q    = q_oe & cell_bit;
  end

  // R4
  no_select_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (row_sel == '0 && col_sel == '0));
  // R4
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel) && $onehot0(col_sel));
  // R6
  hiz_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || ce_n) |-> !q_oe);
  // R6
  quiet_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_oe |-> !q);
  // R5
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n) |-> q_oe);
endmodule

// File: tb/test_latched_sram_1kx1.sv
module test_latched_sram_1kx1;
  logic clk = 1'b0;
  logic rst_n, ce_n, we_n, d;
  logic [9:0] addr;
  logic q, q_oe;
  int n_chk = 0;
  int n_fail = 0;
  logic ref_mem [1024];

  always #5 clk = ~clk;

  latched_sram_1kx1 i_latched_sram_1kx1 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .d(d), .q(q), .q_oe(q_oe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // write access; optional scramble of addr pins after the falling edge
  task automatic do_write(input logic [9:0] a, input logic v, input bit scr);
    @(negedge clk); addr = a; ce_n = 1'b0; we_n = 1'b0; d = v;
    @(negedge clk); if (scr) addr = a ^ 10'h3A5;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; addr = $urandom; d = $urandom;
    ref_mem[a] = v;
  endtask

  task automatic do_read(input logic [9:0] a, input bit scr, input string req);
    @(negedge clk); addr = a; ce_n = 1'b0; we_n = 1'b1;
    #1 check(req, q, ref_mem[a]);
    @(negedge clk); if (scr) addr = ~a;
    #1 check(req, q, ref_mem[a]);
    check("R5", q_oe, 1'b1);
    @(negedge clk); ce_n = 1'b1;
    #1 check("R6", q_oe, 1'b0);
    check("R6", q, 1'b0);
  endtask

  task automatic t_reset;
    #1 check("R8", q_oe, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R8", q_oe, 1'b0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 1024; i++) do_write(i[9:0], ^(i * 7 + 3), 1'b0);
    for (int i = 0; i < 1024; i++) do_read(i[9:0], 1'b0, "R1");
  endtask

  task automatic t_decode;
    do_write(10'd0, 1'b0, 1'b0);
    do_write(10'd32, 1'b1, 1'b0);
    do_write(10'd1, 1'b1, 1'b0);
    do_write(10'd33, 1'b0, 1'b0);
    do_read(10'd0, 1'b0, "R4");
    do_read(10'd32, 1'b0, "R4");
    do_read(10'd1, 1'b0, "R4");
    do_read(10'd33, 1'b0, "R4");
  endtask

  task automatic t_scramble;
    for (int i = 0; i < 200; i++) begin
      logic [9:0] a;
      a = $urandom;
      do_write(a, $urandom, 1'b1);
      do_read(a, 1'b1, "R2");
      do_read(a ^ 10'h3A5, 1'b0, "R2");
    end
  endtask

  task automatic t_idle;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); ce_n = 1'b1; we_n = $urandom; d = $urandom; addr = $urandom;
      #1 check("R6", q_oe, 1'b0);
    end
    for (int i = 0; i < 1024; i += 37) do_read(i[9:0], 1'b0, "R7");
    // R3: consecutive accesses each capture their own address
    for (int i = 0; i < 16; i++) do_read(10'(i * 61), 1'b1, "R3");
  endtask

  task automatic t_wlow;
    @(negedge clk); addr = 10'd77; ce_n = 1'b0; we_n = 1'b0; d = 1'b1;
    #1 check("R6", q_oe, 1'b0);
    check("R6", q, 1'b0);
    @(negedge clk); d = 1'b0;
    @(negedge clk); d = 1'b1; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    ref_mem[77] = 1'b0;
    do_read(10'd77, 1'b0, "R9");
    @(negedge clk); addr = 10'd78; ce_n = 1'b0; we_n = 1'b0; d = 1'b0;
    @(negedge clk); d = 1'b1;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
    ref_mem[78] = 1'b1;
    do_read(10'd78, 1'b0, "R9");
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; d = 1'b0; addr = '0;
    t_reset();
    t_fill();
    t_decode();
    t_scramble();
    t_idle();
    t_wlow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule